// File: doc/BRIEF.md
# Pipelined Signed-Fraction Adder

This block adds two numbers, each held as a sign bit, an unsigned binary exponent and a fraction magnitude. The value of an operand is (-1)^sign * (frac / 2^FRAC_W) * 2^exp. The add is split into four registered stages. The first stage picks the operand with the larger exponent and forms the exponent difference. The second stage shifts the other fraction right to line it up. The third stage adds the magnitudes when the signs agree and subtracts them when they differ. The fourth stage brings the result into the range [0.5, 1) and corrects its exponent. There is no rounding. Bits shifted out are dropped. Infinities, NaNs and denormals are not represented.

Operands enter on a valid/ready stream and results leave on another. A pair is taken on each clock edge where `in_valid` and `in_ready` are both high. A result is handed over on each edge where `out_valid` and `out_ready` are both high. When the output holds a result that the sink refuses, the whole pipeline freezes and `in_ready` drops in the same cycle, because `in_ready` = !`out_valid` || `out_ready`. `in_ready` therefore follows `out_ready` combinationally. A source may drop `in_valid` at any time. Results come out in the order their operands went in.

Top module: `fpa_pipe_add`

## Requirements
- R1: When the sink keeps `out_ready` high, a pair taken in cycle c appears on the output, with `out_valid` high, in cycle c+4. A new pair can be taken in every cycle.
- R2: While `out_valid` is high and `out_ready` is low, the output fields and `out_valid` hold their values and `in_ready` is low. Whenever `out_valid` is low, `in_ready` is high.
- R3: While reset (`rst_n` low) is asserted and after it is released, `out_valid` is low and `in_ready` is high until a pair has passed through.
- R4: The fraction of the operand with the smaller exponent is shifted right by the exponent difference, and the bits shifted out are dropped. A difference of FRAC_W or more makes that fraction zero. When the exponents are equal, operand a counts as the larger one.
- R5: Equal signs add the magnitudes and keep the common sign. Different signs subtract the smaller magnitude from the larger, and the result takes the sign of the larger magnitude.
- R6: A nonzero in-range result has `out_frac` bit FRAC_W-1 set, so 0.5 <= d < 1. The fraction is shifted left by its leading-zero count, and the larger exponent is reduced by that same count.
- R7: When the magnitude sum reaches 1 or more, the fraction is shifted right by one, dropping its least significant bit, and the exponent is raised by one.
- R8: A zero magnitude sum gives all-zero sign, exponent and fraction fields.
- R9: When the leading-zero count is larger than the exponent, the result is flushed to all-zero fields.
- R10: A sum that reaches 1 or more while the larger exponent is already at its maximum saturates. The exponent is all ones, the fraction is all ones and the sign is kept.
- R11: A burst of n back-to-back pairs with the sink always ready has its last result registered 4 + n - 1 cycles after the cycle in which the first pair was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Pipeline can take a pair this cycle |
| a_sign | input | 1 | Sign of operand a (1 = negative) |
| a_exp | input | EXP_W | Unsigned exponent of operand a |
| a_frac | input | FRAC_W | Fraction magnitude of operand a |
| b_sign | input | 1 | Sign of operand b |
| b_exp | input | EXP_W | Unsigned exponent of operand b |
| b_frac | input | FRAC_W | Fraction magnitude of operand b |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result this cycle |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result exponent |
| out_frac | output | FRAC_W | Normalized result fraction |

## Verification
The bench uses a 4-bit fraction and a 3-bit exponent. It sweeps every pair of signs, exponents and fractions, so every alignment distance, including the full-flush shift, is paired with every mix of same and opposite signs. This sweep separates the plain add from cancellation that needs a long left shift, from carry-out, from exponent flush and from saturation, and each outcome is checked against an arithmetic reference. A second stream runs under a repeating pattern of sink stalls. It shows whether held results stay frozen and whether ordering survives back-pressure. A short burst then measures first-result latency and the total time for the burst.

// File: rtl/fpa_pkg.sv
`timescale 1ns/1ps
package fpa_pkg;
  // outcome chosen by the final normalize stage
  typedef enum logic [2:0] {
    K_NORM  = 3'd0,
    K_CARRY = 3'd1,
    K_SAT   = 3'd2,
    K_ZERO  = 3'd3,
    K_FLUSH = 3'd4
  } norm_kind_e;
endpackage

// File: rtl/fpa_s1_expcmp.sv
`timescale 1ns/1ps
module fpa_s1_expcmp #(
  parameter int FW = 24,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_v,
  input  logic          a_sign,
  input  logic [EW-1:0] a_exp,
  input  logic [FW-1:0] a_frac,
  input  logic          b_sign,
  input  logic [EW-1:0] b_exp,
  input  logic [FW-1:0] b_frac,
  output logic          q_v,
  output logic          q_big_sign,
  output logic [FW-1:0] q_big_frac,
  output logic          q_sml_sign,
  output logic [FW-1:0] q_sml_frac,
  output logic [EW-1:0] q_r_exp,
  output logic [EW-1:0] q_diff
);
  logic          a_wins;
  logic [EW-1:0] d_ab, d_ba;

  always_comb begin
    d_ab   = a_exp - b_exp;
    d_ba   = b_exp - a_exp;
    a_wins = (a_exp >= b_exp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v        <= 1'b0;
      q_big_sign <= 1'b0;
      q_big_frac <= '0;
      q_sml_sign <= 1'b0;
      q_sml_frac <= '0;
      q_r_exp    <= '0;
      q_diff     <= '0;
    end else if (adv) begin
      q_v <= in_v;
      if (a_wins) begin
        q_big_sign <= a_sign;
        q_big_frac <= a_frac;
        q_sml_sign <= b_sign;
        q_sml_frac <= b_frac;
        q_r_exp    <= a_exp;
        q_diff     <= d_ab;
      end else begin
        q_big_sign <= b_sign;
        q_big_frac <= b_frac;
        q_sml_sign <= a_sign;
        q_sml_frac <= a_frac;
        q_r_exp    <= b_exp;
        q_diff     <= d_ba;
      end
    end
  end
endmodule

// File: rtl/fpa_s2_align.sv
`timescale 1ns/1ps
module fpa_s2_align #(
  parameter int FW = 24,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_v,
  input  logic          big_sign,
  input  logic [FW-1:0] big_frac,
  input  logic          sml_sign,
  input  logic [FW-1:0] sml_frac,
  input  logic [EW-1:0] r_exp,
  input  logic [EW-1:0] diff,
  output logic          q_v,
  output logic          q_big_sign,
  output logic [FW-1:0] q_big_frac,
  output logic          q_sml_sign,
  output logic [FW-1:0] q_al_frac,
  output logic [EW-1:0] q_r_exp
);
  logic [FW-1:0] aligned;

  always_comb begin
    if (32'(diff) >= FW) aligned = '0;
    else                 aligned = sml_frac >> diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v        <= 1'b0;
      q_big_sign <= 1'b0;
      q_big_frac <= '0;
      q_sml_sign <= 1'b0;
      q_al_frac  <= '0;
      q_r_exp    <= '0;
    end else if (adv) begin
      q_v        <= in_v;
      q_big_sign <= big_sign;
      q_big_frac <= big_frac;
      q_sml_sign <= sml_sign;
      q_al_frac  <= aligned;
      q_r_exp    <= r_exp;
    end
  end
endmodule

// File: rtl/fpa_s3_addsub.sv
`timescale 1ns/1ps
module fpa_s3_addsub #(
  parameter int FW = 24,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_v,
  input  logic          big_sign,
  input  logic [FW-1:0] big_frac,
  input  logic          sml_sign,
  input  logic [FW-1:0] al_frac,
  input  logic [EW-1:0] r_exp,
  output logic          q_v,
  output logic          q_sign,
  output logic [FW:0]   q_sum,
  output logic [EW-1:0] q_r_exp
);
  logic [FW:0] ext_big, ext_al, mag;
  logic        sgn;

  always_comb begin
    ext_big = {1'b0, big_frac};
    ext_al  = {1'b0, al_frac};
    if (big_sign == sml_sign) begin
      mag = ext_big + ext_al;
      sgn = big_sign;
    end else if (ext_big >= ext_al) begin
      mag = ext_big - ext_al;
      sgn = big_sign;
    end else begin
      mag = ext_al - ext_big;
      sgn = sml_sign;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v     <= 1'b0;
      q_sign  <= 1'b0;
      q_sum   <= '0;
      q_r_exp <= '0;
    end else if (adv) begin
      q_v     <= in_v;
      q_sign  <= sgn;
      q_sum   <= mag;
      q_r_exp <= r_exp;
    end
  end
endmodule

// File: rtl/fpa_s4_norm.sv
`timescale 1ns/1ps
module fpa_s4_norm
  import fpa_pkg::*;
#(
  parameter int FW = 24,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_v,
  input  logic          sum_sign,
  input  logic [FW:0]   sum,
  input  logic [EW-1:0] r_exp,
  output logic          q_v,
  output logic          q_sign,
  output logic [EW-1:0] q_exp,
  output logic [FW-1:0] q_frac
);
  localparam int LZ_W  = $clog2(FW + 1);
  localparam int CMP_W = ((EW > LZ_W) ? EW : LZ_W) + 1;

  logic [LZ_W-1:0]  lz;
  logic [CMP_W-1:0] lz_c, r_c;
  norm_kind_e       kind;
  logic             n_sign;
  logic [EW-1:0]    n_exp;
  logic [FW-1:0]    n_frac;

  // leading-zero count over the in-range bits; highest set bit wins
  always_comb begin
    lz = LZ_W'(FW);
    for (int i = 0; i < FW; i++) begin
      if (sum[i]) lz = LZ_W'(FW - 1 - i);
    end
    lz_c = CMP_W'(lz);
    r_c  = CMP_W'(r_exp);
  end

  always_comb begin
    if (sum[FW])            kind = (&r_exp) ? K_SAT : K_CARRY;
    else if (sum == '0)     kind = K_ZERO;
    else if (lz_c > r_c)    kind = K_FLUSH;
    else                    kind = K_NORM;
  end

  always_comb begin
    n_sign = 1'b0;
    n_exp  = '0;
    n_frac = '0;
    case (kind)
      K_CARRY: begin
        n_sign = sum_sign;
        n_exp  = r_exp + 1'b1;
        n_frac = sum[FW:1];
      end
      K_SAT: begin
        n_sign = sum_sign;
        n_exp  = '1;
        n_frac = '1;
      end
      K_NORM: begin
        n_sign = sum_sign;
        n_exp  = r_exp - EW'(lz);
        n_frac = sum[FW-1:0] << lz;
      end
      default: begin
        n_sign = 1'b0;
        n_exp  = '0;
        n_frac = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v    <= 1'b0;
      q_sign <= 1'b0;
      q_exp  <= '0;
      q_frac <= '0;
    end else if (adv) begin
      q_v    <= in_v;
      q_sign <= n_sign;
      q_exp  <= n_exp;
      q_frac <= n_frac;
    end
  end
endmodule

// File: rtl/fpa_pipe_add.sv
`timescale 1ns/1ps
module fpa_pipe_add #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [FRAC_W-1:0] a_frac,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [FRAC_W-1:0] b_frac,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [FRAC_W-1:0] out_frac
);
  logic adv;

  logic              s1_v, s1_bs, s1_ss;
  logic [FRAC_W-1:0] s1_bf, s1_sf;
  logic [EXP_W-1:0]  s1_r, s1_d;

  logic              s2_v, s2_bs, s2_ss;
  logic [FRAC_W-1:0] s2_bf, s2_af;
  logic [EXP_W-1:0]  s2_r;

  logic              s3_v, s3_s;
  logic [FRAC_W:0]   s3_sum;
  logic [EXP_W-1:0]  s3_r;

  // global freeze: every stage moves only when the output slot can move
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  fpa_s1_expcmp #(.FW(FRAC_W), .EW(EXP_W)) u_s1 (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_v(in_valid),
    .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
    .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
    .q_v(s1_v), .q_big_sign(s1_bs), .q_big_frac(s1_bf),
    .q_sml_sign(s1_ss), .q_sml_frac(s1_sf), .q_r_exp(s1_r), .q_diff(s1_d)
  );

  fpa_s2_align #(.FW(FRAC_W), .EW(EXP_W)) u_s2 (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_v(s1_v),
    .big_sign(s1_bs), .big_frac(s1_bf), .sml_sign(s1_ss), .sml_frac(s1_sf),
    .r_exp(s1_r), .diff(s1_d),
    .q_v(s2_v), .q_big_sign(s2_bs), .q_big_frac(s2_bf),
    .q_sml_sign(s2_ss), .q_al_frac(s2_af), .q_r_exp(s2_r)
  );

  fpa_s3_addsub #(.FW(FRAC_W), .EW(EXP_W)) u_s3 (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_v(s2_v),
    .big_sign(s2_bs), .big_frac(s2_bf), .sml_sign(s2_ss), .al_frac(s2_af),
    .r_exp(s2_r),
    .q_v(s3_v), .q_sign(s3_s), .q_sum(s3_sum), .q_r_exp(s3_r)
  );

  fpa_s4_norm #(.FW(FRAC_W), .EW(EXP_W)) u_s4 (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_v(s3_v),
    .sum_sign(s3_s), .sum(s3_sum), .r_exp(s3_r),
    .q_v(out_valid), .q_sign(out_sign), .q_exp(out_exp), .q_frac(out_frac)
  );
endmodule

// File: rtl/fpa_pipe_chk.sv
`timescale 1ns/1ps
module fpa_pipe_chk #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sign,
  input logic [EXP_W-1:0]  out_exp,
  input logic [FRAC_W-1:0] out_frac
);
  // R2: a refused result stays put
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_frac) &&
                                   $stable(out_exp) && $stable(out_sign)));

  // R2: empty output slot always lets a pair in
  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R1: with the sink ready throughout, an accepted pair surfaces four cycles on
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 4) && $past(out_ready, 1) &&
     $past(out_ready, 2) && $past(out_ready, 3)) |-> out_valid);

  // R6: nonzero results sit in [0.5, 1)
  p_norm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_frac != '0) |-> out_frac[FRAC_W-1]);

  // R8: a zero fraction carries zero sign and exponent
  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_frac == '0) |-> (out_exp == '0 && !out_sign));
endmodule

bind fpa_pipe_add fpa_pipe_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) chk_i (.*);

// File: tb/fpa_pipe_add_tb_top.sv
`timescale 1ns/1ps
module fpa_pipe_add_tb_top;
  localparam int FW = 4;
  localparam int EW = 3;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          a_sign = 1'b0, b_sign = 1'b0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic [FW-1:0] a_frac = '0, b_frac = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          out_sign;
  logic [EW-1:0] out_exp;
  logic [FW-1:0] out_frac;

  int checks = 0;
  int fails  = 0;
  int neg_cnt = 0;
  bit lat_en = 1'b1;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  int         tag_q[$];
  int         time_q[$];

  int burst_first_push = -1;
  int last_pop_time = 0;

  logic       held_v = 1'b0;
  logic [7:0] held_val = '0;

  always #2 clk = ~clk;

  fpa_pipe_add #(.FRAC_W(FW), .EXP_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
    .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sign(out_sign), .out_exp(out_exp), .out_frac(out_frac)
  );

  function automatic string tag_name(input int t);
    case (t)
      4:  return "R4";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R8";
      9:  return "R9";
      10: return "R10";
      default: return "R5";
    endcase
  endfunction

  // arithmetic reference: result packed as {sign, exp[2:0], frac[3:0]}
  function automatic void ref_add(input int as_, input int ae, input int af,
                                  input int bs_, input int be, input int bf,
                                  output logic [7:0] res, output int tag);
    int bgs, bge, bgf, sms, smf, t, al, sum, sg, lz;
    if (ae >= be) begin
      bgs = as_; bge = ae; bgf = af; sms = bs_; smf = bf; t = ae - be;
    end else begin
      bgs = bs_; bge = be; bgf = bf; sms = as_; smf = af; t = be - ae;
    end
    al  = (t >= FW) ? 0 : (smf >> t);
    tag = (t > 0) ? 4 : 5;
    if (bgs == sms) begin sum = bgf + al; sg = bgs; end
    else if (bgf >= al) begin sum = bgf - al; sg = bgs; end
    else begin sum = al - bgf; sg = sms; end
    if (sum >= 16) begin
      if (bge == 7) begin res = {sg[0], 3'd7, 4'hF}; tag = 10; end
      else begin res = {sg[0], 3'(bge + 1), 4'(sum >> 1)}; tag = 7; end
    end else if (sum == 0) begin
      res = 8'h00; tag = 8;
    end else begin
      lz = 0;
      while (((sum << lz) & 8) == 0) lz++;
      if (lz > bge) begin res = 8'h00; tag = 9; end
      else begin
        res = {sg[0], 3'(bge - lz), 4'((sum << lz) & 15)};
        if (lz > 0) tag = 6;
      end
    end
  endfunction

  task automatic report_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // monitor: sample at the falling edge, away from the active edge
  always @(negedge clk) begin
    logic [7:0] r;
    int tg;
    neg_cnt++;
    if (rst_n) begin
      // R2: frozen output while refused
      if (held_v) begin
        checks++;
        if (!out_valid || {out_sign, out_exp, out_frac} != held_val) begin
          fails++;
          $display("FAIL R2 hold: got v=%0b %h exp v=1 %h", out_valid,
                   {out_sign, out_exp, out_frac}, held_val);
        end
      end
      if (out_valid && !out_ready) begin
        checks++;
        if (in_ready) begin
          fails++;
          $display("FAIL R2 in_ready: got 1 exp 0");
        end
        held_v = 1'b1;
        held_val = {out_sign, out_exp, out_frac};
      end else begin
        held_v = 1'b0;
      end
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected result %h exp none", {out_sign, out_exp, out_frac});
        end else begin
          r  = exp_q.pop_front();
          tg = tag_q.pop_front();
          if ({out_sign, out_exp, out_frac} != r) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag_name(tg), {out_sign, out_exp, out_frac}, r);
          end
          tg = time_q.pop_front();
          if (lat_en) begin
            checks++;
            if (neg_cnt - tg != 4) begin
              fails++;
              $display("FAIL R1 latency got %0d exp 4", neg_cnt - tg);
            end
          end
          last_pop_time = neg_cnt;
        end
      end
      if (in_valid && in_ready) begin
        ref_add(int'(a_sign), int'(a_exp), int'(a_frac),
                int'(b_sign), int'(b_exp), int'(b_frac), r, tg);
        exp_q.push_back(r);
        tag_q.push_back(tg);
        time_q.push_back(neg_cnt);
      end
    end
  end

  // sink stall pattern
  int stall_cyc = 0;
  always @(posedge clk) begin
    #1;
    if (stall_mode) begin
      stall_cyc++;
      out_ready = ((stall_cyc % 5) >= 2);
    end else begin
      out_ready = 1'b1;
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      report_and_end();
    end
  end

  task automatic send(input int as_, input int ae, input int af,
                      input int bs_, input int be, input int bf);
    a_sign = as_[0]; a_exp = EW'(ae); a_frac = FW'(af);
    b_sign = bs_[0]; b_exp = EW'(be); b_frac = FW'(bf);
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R3: reset state
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R3 reset: got v=%b rdy=%b exp v=0 rdy=1", out_valid, in_ready);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R3 after release: got v=%b rdy=%b exp v=0 rdy=1", out_valid, in_ready);
    end
    @(posedge clk);
    #1;

    // full sweep: R4..R10 (tags chosen per vector by the reference)
    for (int ae = 0; ae < 8; ae++)
      for (int be = 0; be < 8; be++)
        for (int sg = 0; sg < 4; sg++)
          for (int af = 0; af < 16; af++)
            for (int bf = 0; bf < 16; bf++)
              send(sg & 1, ae, af, sg >> 1, be, bf);
    drain();

    // back-pressure stream: R2 with ordering under stalls
    lat_en = 1'b0;
    stall_mode = 1'b1;
    for (int i = 0; i < 300; i++)
      send(i & 1, (i * 3) % 8, (i * 7) % 16, (i >> 1) & 1, (i * 5) % 8, (i * 11) % 16);
    drain();
    stall_mode = 1'b0;
    @(posedge clk);
    #1;
    lat_en = 1'b1;

    // R11: burst of five back-to-back pairs
    burst_first_push = neg_cnt + 1;
    for (int i = 0; i < 5; i++) send(0, 4, 8 + i, 0, 2, 15 - i);
    drain();
    checks++;
    if (last_pop_time - burst_first_push != 4 + 5 - 1) begin
      fails++;
      $display("FAIL R11 burst span got %0d exp %0d",
               last_pop_time - burst_first_push, 4 + 5 - 1);
    end

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      report_and_end();
    end
  end
endmodule